// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block turns a stream of 10-bit parallel words into a single serial bit line. It runs on the bit-rate clock and keeps its own 12-slot frame position counter. Once per frame it samples the parallel word and sends it as a 12-bit frame: a high start bit, then the ten data bits with the least significant bit first, then a low stop bit. So every frame boundary carries a low-to-high step that a receiver can use to recover the clock. The serial rate is twelve bits per word, and the payload is ten of those bits.

After reset the line driver enable stays low, and the data line is held low, until a fixed number of frame periods has passed. This models the wait for the transmit clock generator to settle. The first frame sent once the driver is enabled always carries an all-zero payload, so that a receiver that lost sync while the line was floating can lock again. A resync input lets the system force further all-zero frames at any time. A pulse output tells the data source in which cycle the word is taken.

Top module: `framed_ser_tx`

## Requirements
- R1: Each enabled frame takes 12 clock cycles. Slot 0 carries 1 (the start bit). Slots 1 to 10 carry payload bits 0 to 9 in that order. Slot 11 carries 0 (the stop bit).
- R2: `word_take` is high only in slot 11, the first time 11 clock edges after reset release and then every 12 cycles. `word_in` and `resync` are sampled at the end of that cycle and have no effect on the serial output at any other time.
- R3: After reset release `tx_oe` stays low for LOCK_WORDS×12 − 1 clock edges. It rises at edge LOCK_WORDS×12 (24576 with defaults), at the start of a frame, and stays high until the next reset.
- R4: While `tx_oe` is low, `tx_data` is 0.
- R5: The first frame sent with `tx_oe` high has an all-zero payload, whatever value `word_in` has. The frame after it carries the sampled word.
- R6: When `resync` is 1 in a `word_take` cycle, the following frame has an all-zero payload.
- R7: `locked` equals `tx_oe` in every cycle.
- R8: Reset is synchronous and active low. While `rst_n` is low at a clock edge, `tx_oe`, `locked` and `tx_data` go to 0, and the frame counter restarts at slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | DATA_W (10) | Parallel payload word |
| resync | input | 1 | Force an all-zero payload in the next frame |
| word_take | output | 1 | High in the cycle whose end samples `word_in` |
| tx_data | output | 1 | Serial data line |
| tx_oe | output | 1 | Line driver enable; low means high impedance |
| locked | output | 1 | Lock status, mirrors `tx_oe` |

## Verification
The hardest situation to reach from the ports is the instant the driver enable first rises. Getting there takes more than twenty-four thousand cycles of waiting. At that instant the enable, the first frame load and the forced zero payload all meet on one clock edge. The bench drives nonzero random words throughout the lock wait and counts edges from reset release. It checks the enable on both sides of the exact edge. It then confirms that the first enabled frame is all zero and that the next frame carries the sampled word. Random words and resync requests are also changed in the middle of each frame, to show that only the value present in the take cycle matters.

// File: rtl/txl_pkg.sv
// Shared constants for the framed serial transmitter.
// Assumes: frame = start bit, payload (LSB first), stop bit.
package txl_pkg;
    localparam int  TXL_DATA_W_DEF     = 10;
    localparam int  TXL_LOCK_WORDS_DEF = 2048;
    localparam logic TXL_START_LVL     = 1'b1;
    localparam logic TXL_STOP_LVL      = 1'b0;
endpackage

// File: rtl/txl_slot_ctr.sv
// Frame slot counter: counts bit slots 0..FRAME_W-1 and wraps.
// Assumes: one slot per clock, restart at slot 0 on reset.
module txl_slot_ctr #(
    parameter int FRAME_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_first,
    output logic slot_last
);
    localparam int SW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [SW-1:0] LAST = SW'(FRAME_W - 1);

    logic [SW-1:0] slot_q;

    // Advance the slot position, wrapping after the stop slot.
    always_ff @(posedge clk) begin
        if (!rst_n)              slot_q <= '0;
        else if (slot_q == LAST) slot_q <= '0;
        else                     slot_q <= slot_q + 1'b1;
    end

    assign slot_first = (slot_q == '0);
    assign slot_last  = (slot_q == LAST);
endmodule

// File: rtl/txl_lock_timer.sv
// Lock wait timer: counts frame boundaries after reset and enables
// the line driver once LOCK_WORDS of them have passed. Sticky until reset.
// Assumes: boundary_i pulses once per frame in the last slot.
module txl_lock_timer #(
    parameter int LOCK_WORDS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary_i,
    output logic oe_o,
    output logic oe_next_o
);
    localparam int CW = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOCK_WORDS - 1);

    logic [CW-1:0] cnt_q;
    logic          oe_q;
    logic          hit;

    assign hit = boundary_i && !oe_q && (cnt_q == LAST);

    // Count boundaries until the wait completes, then hold the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            oe_q  <= 1'b0;
        end else if (hit) begin
            oe_q  <= 1'b1;
        end else if (boundary_i && !oe_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign oe_o      = oe_q;
    assign oe_next_o = oe_q | hit;

    // R3: once enabled, the driver stays enabled until reset.
    a_r3_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |=> oe_q);
endmodule

// File: rtl/txl_frame_shifter.sv
// Frame shifter: loads {stop, payload, start} at each frame boundary and
// shifts one bit per clock, LSB first. It zeroes the payload before lock,
// for the first enabled frame, and on a resync request.
module txl_frame_shifter #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              oe_i,
    input  logic              oe_next_i,
    input  logic              resync_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              bit_o
);
    import txl_pkg::*;
    localparam int FRAME_W = DATA_W + 2;

    logic [FRAME_W-1:0] sh_q;
    logic               zero_pend_q;
    logic               blank;
    logic [DATA_W-1:0]  payload;

    assign blank   = !oe_next_i || zero_pend_q || resync_i;
    assign payload = blank ? '0 : word_i;

    // Load a new frame at the boundary, otherwise shift toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      sh_q <= '0;
        else if (take_i) sh_q <= {TXL_STOP_LVL, payload, TXL_START_LVL};
        else             sh_q <= {1'b0, sh_q[FRAME_W-1:1]};
    end

    // Track the pending all-zero frame owed after enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                      zero_pend_q <= 1'b1;
        else if (take_i && oe_next_i)    zero_pend_q <= 1'b0;
    end

    assign bit_o = sh_q[0];

    // R5: the frame loaded as the enable rises has a zero payload.
    a_r5_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_i) |-> (sh_q[DATA_W:1] == '0));
    // R6: a resync request in the take cycle yields a zero payload.
    a_r6_resync_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && resync_i) |=> (sh_q[DATA_W:1] == '0));
endmodule

// File: rtl/framed_ser_tx.sv
// Framed serial word transmitter top: slot counter, lock timer and
// frame shifter. It gates the serial line low while the driver is disabled.
// Assumes: word_in is stable in the cycle word_take is high.
module framed_ser_tx #(
    parameter int DATA_W     = txl_pkg::TXL_DATA_W_DEF,
    parameter int LOCK_WORDS = txl_pkg::TXL_LOCK_WORDS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word_in,
    input  logic              resync,
    output logic              word_take,
    output logic              tx_data,
    output logic              tx_oe,
    output logic              locked
);
    localparam int FRAME_W = DATA_W + 2;

    logic slot_first;
    logic slot_last;
    logic oe;
    logic oe_next;
    logic sh_bit;

    txl_slot_ctr #(.FRAME_W(FRAME_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_first (slot_first),
        .slot_last  (slot_last)
    );

    txl_lock_timer #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (slot_last),
        .oe_o       (oe),
        .oe_next_o  (oe_next)
    );

    txl_frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (slot_last),
        .oe_i      (oe),
        .oe_next_i (oe_next),
        .resync_i  (resync),
        .word_i    (word_in),
        .bit_o     (sh_bit)
    );

    assign word_take = slot_last;
    assign tx_oe     = oe;
    assign locked    = oe;
    assign tx_data   = oe & sh_bit;

    // R1: start slot is high and stop slot is low while enabled.
    a_r1_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe && slot_first) |-> tx_data);
    a_r1_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe && slot_last) |-> !tx_data);
    // R3: the enable rises only at the start of a frame.
    a_r3_oe_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> slot_first);
    // R4: the line is quiet while disabled.
    a_r4_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_data);
    // R8: reset clears the enable and the line.
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!tx_oe && !tx_data && !locked));
endmodule

// File: tb/framed_ser_tx_bench.sv
module framed_ser_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 10;
    localparam int LOCK = 2048;
    localparam int FW   = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] word_in = '0;
    logic          resync = 1'b0;
    logic          word_take, tx_data, tx_oe, locked;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned mirror_bad = 0;
    int unsigned quiet_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    framed_ser_tx #(.DATA_W(DW), .LOCK_WORDS(LOCK)) u_framed_ser_tx (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .resync(resync),
        .word_take(word_take), .tx_data(tx_data), .tx_oe(tx_oe), .locked(locked)
    );

    // R7 monitor: locked must track tx_oe; R4 monitor: quiet when disabled.
    always @(negedge clk) begin
        if (locked !== tx_oe) mirror_bad++;
        if (!tx_oe && tx_data !== 1'b0) quiet_bad++;
    end

    function automatic logic exp_bit(input int slot, input logic [DW-1:0] pl);
        if (slot == 0)       return 1'b1;
        else if (slot == FW-1) return 1'b0;
        else                 return pl[slot-1];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Checks 12 slots starting at the slot-0 negedge; returns at slot 11.
    task automatic check_frame(input logic [DW-1:0] pl, input string req);
        bit ok = 1'b1;
        logic [FW-1:0] got = '0;
        logic [FW-1:0] want = '0;
        for (int s = 0; s < FW; s++) begin
            if (s > 0) @(negedge clk);
            got[s]  = tx_data;
            want[s] = exp_bit(s, pl);
            if (tx_data !== want[s]) ok = 1'b0;
            if (s < FW-1) begin
                word_in = DW'($urandom);
                resync  = ($urandom % 2) == 1;
            end
        end
        chk(ok, req, int'(got), int'(want));
        chk(word_take === 1'b1, "R2 take in slot 11", int'(word_take), 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R8: hold reset across several edges.
        repeat (4) @(negedge clk);
        chk(tx_oe === 1'b0 && tx_data === 1'b0 && locked === 1'b0,
            "R8 reset state", int'({tx_oe, tx_data, locked}), 0);
        rst_n = 1'b1;
        // R2: first take after 11 edges from release.
        repeat (10) @(negedge clk);
        chk(word_take === 1'b0, "R2 no take at edge 10", int'(word_take), 0);
        @(negedge clk);
        chk(word_take === 1'b1, "R2 take at edge 11", int'(word_take), 1);
        // Lock wait with random nonzero words (total edges so far: 11).
        for (int e = 11; e < LOCK*FW - 1; e++) begin
            word_in = DW'($urandom) | DW'(1);
            resync  = 1'b0;
            @(negedge clk);
        end
        chk(tx_oe === 1'b0, "R3 oe low one edge before lock", int'(tx_oe), 0);
        chk(quiet_bad == 0, "R4 line quiet during lock wait", int'(quiet_bad), 0);
        word_in = 10'h3FF;
        @(negedge clk);
        chk(tx_oe === 1'b1, "R3 oe high at lock edge", int'(tx_oe), 1);
        // R5: first enabled frame is zero regardless of word_in.
        check_frame('0, "R5 first frame zero");
        // R5: next frame carries the word.
        word_in = 10'h2A5; resync = 1'b0;
        @(negedge clk);
        check_frame(10'h2A5, "R5 data after zero frame");
        // R1 directed patterns: all ones, single bits.
        word_in = 10'h3FF; resync = 1'b0;
        @(negedge clk);
        check_frame(10'h3FF, "R1 all ones frame");
        word_in = 10'h001; resync = 1'b0;
        @(negedge clk);
        check_frame(10'h001, "R1 bit0 first");
        word_in = 10'h200; resync = 1'b0;
        @(negedge clk);
        check_frame(10'h200, "R1 bit9 last");
        // R6 directed: resync with nonzero word.
        word_in = 10'h155; resync = 1'b1;
        @(negedge clk);
        check_frame('0, "R6 resync zero frame");
        // Random frames with mid-frame input churn (R2) and resync (R6).
        for (int f = 0; f < 40; f++) begin
            logic [DW-1:0] w = DW'($urandom);
            logic          r = ($urandom % 4) == 0;
            word_in = w; resync = r;
            @(negedge clk);
            check_frame(r ? '0 : w, r ? "R6 random resync" : "R2 random frame");
        end
        chk(tx_oe === 1'b1, "R3 oe stays high", int'(tx_oe), 1);
        // R8: reset while running.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_oe === 1'b0 && tx_data === 1'b0 && locked === 1'b0,
            "R8 reset mid-run", int'({tx_oe, tx_data, locked}), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(word_take === 1'b0, "R8 slot restart edge 10", int'(word_take), 0);
        @(negedge clk);
        chk(word_take === 1'b1, "R8 slot restart edge 11", int'(word_take), 1);
        repeat (200) @(negedge clk);
        chk(tx_oe === 1'b0, "R3 oe low again after reset", int'(tx_oe), 0);
        chk(mirror_bad == 0, "R7 locked mirrors tx_oe", int'(mirror_bad), 0);
        chk(quiet_bad == 0, "R4 line quiet when disabled", int'(quiet_bad), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule